// File: doc/BRIEF.md
# Snoop Coherence State Updater

This block sits between the snoop port of a system bus and the state store of a direct-mapped cache. It handles one snooped transaction at a time. It looks up the addressed block in an internal tag/state register file. It then decides whether modified data has to be pushed out and which coherence state the block takes next. The cache side can load entries through a fill port and read back the state of any address through a lookup port.

Two parameters select the variant:

- `MESI_EN` chooses a four-state protocol or a three-state protocol that never holds Shared.
- `ICBI_SNOOP_EN` enables or disables reaction to instruction-cache block invalidate broadcasts.

A plain snooped read is handled differently from a read that declares it will not cache the data. When the latter hits a modified block, the block is written back and kept Exclusive, so the local processor keeps write access without another bus operation.

While a push is outstanding, the block asks the bus to retry. It holds the push request and its address stable. It commits the new state only when the push is acknowledged.

Top module: `snoop_coherence_unit`

## Requirements
- R1: After reset every entry is Invalid, so the lookup port returns 2'b00 for every address, and `push_req_o`, `retry_o` and `wr_valid_o` are low. State encoding is I=2'b00, S=2'b01, E=2'b10, M=2'b11. The address splits as offset bits [4:0], index bits [7:5] and tag bits [31:8].
- R2: A snooped read with no intent to cache (TT=5'b01011) that hits an M block raises a push request. After the acknowledge, the block is E.
- R3: With `MESI_EN`=1, a plain snooped read (TT=5'b01010) that hits an M block raises a push request. After the acknowledge, the block is S.
- R4: With `MESI_EN`=0, a plain snooped read that hits an M block raises a push and then invalidates the block. A fill with state S is stored as E, and no state write ever carries S.
- R5: Once a push starts, `push_req_o` and `retry_o` stay high and `push_addr_o` (the block-aligned snoop address) stays stable until `push_done_i`. The new state is written in the cycle `push_done_i` is sampled high. Snoops presented while a push is pending are ignored.
- R6: With `ICBI_SNOOP_EN`=1, an instruction-cache block invalidate (TT=5'b01101) that hits a valid block invalidates it in the accepting cycle, with no push.
- R7: With `ICBI_SNOOP_EN`=0, an invalidate broadcast causes no state write and no push.
- R8: A read of either kind that hits an E or S block causes no push and no state write. The state is left unchanged.
- R9: A snoop whose tag does not match, or whose entry is Invalid, causes no push and no state write.
- R10: Snoops with any other TT code have no effect on the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snp_valid_i | input | 1 | Snooped transaction present |
| snp_tt_i | input | 5 | Snooped transfer-type code |
| snp_addr_i | input | ADDR_W | Snooped address |
| fill_valid_i | input | 1 | Cache-side entry load |
| fill_addr_i | input | ADDR_W | Address of the entry to load |
| fill_state_i | input | 2 | State to load |
| look_addr_i | input | ADDR_W | Cache-side lookup address |
| look_state_o | output | 2 | State of the looked-up block, I on miss |
| push_req_o | output | 1 | Request to write back a modified block |
| push_addr_o | output | ADDR_W | Block-aligned push address |
| push_done_i | input | 1 | Push acknowledge |
| retry_o | output | 1 | Bus retry/hold while a push is pending |
| wr_valid_o | output | 1 | Snoop-driven state write strobe |
| wr_idx_o | output | IDX_W | Index written |
| wr_state_o | output | 2 | New state written |

## Verification
Two instances run in lockstep on the same snoop and fill stimulus:

- one uses the four-state protocol with invalidate snooping enabled;
- the other uses the three-state protocol with invalidate snooping disabled.

Because they share stimulus, every M-block read separates the S, I and E outcomes by variant and by read type, and every invalidate broadcast shows the enable option's effect.

Random operations draw indices and tags from a small pool, so hits, misses on a different tag, and hits on I, S, E and M entries all occur often. Unlisted TT codes are mixed in. Directed cases cover the reset state, the no-intent read, an S fill in the three-state variant, and a snoop presented during a pending push.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10, ST_M = 2'b11} cstate_e;
  localparam logic [4:0] TT_READ    = 5'b01010;
  localparam logic [4:0] TT_READ_NC = 5'b01011;
  localparam logic [4:0] TT_ICBI    = 5'b01101;
endpackage

// File: rtl/snoop_tag_array.sv
module snoop_tag_array
  import snoop_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int IDX_W = 3,
  parameter int TAG_W = 24,
  parameter int NRD   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [TAG_W-1:0] wtag_i,
  input  cstate_e          wst_i,
  input  logic [IDX_W-1:0] ridx_i [NRD],
  input  logic [TAG_W-1:0] rtag_i [NRD],
  output logic             hit_o  [NRD],
  output cstate_e          st_o   [NRD]
);
  logic [TAG_W-1:0] tag_q [SETS];
  cstate_e          st_q  [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SETS; i++) st_q[i] <= ST_I;
    end else if (we_i) begin
      st_q[widx_i] <= wst_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) tag_q[widx_i] <= wtag_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign st_o[g]  = st_q[ridx_i[g]];
    assign hit_o[g] = (st_q[ridx_i[g]] != ST_I) && (tag_q[ridx_i[g]] == rtag_i[g]);
  end
endmodule

// File: rtl/snoop_policy.sv
module snoop_policy
  import snoop_pkg::*;
#(
  parameter bit MESI_EN       = 1'b1,
  parameter bit ICBI_SNOOP_EN = 1'b1
) (
  input  logic       valid_i,
  input  logic [4:0] tt_i,
  input  logic       hit_i,
  input  cstate_e    st_i,
  output logic       push_o,
  output logic       write_o,
  output cstate_e    next_o
);
  cstate_e rd_next;

  if (MESI_EN) begin : g_mesi
    assign rd_next = ST_S;
  end else begin : g_mei
    assign rd_next = ST_I;
  end

  always_comb begin
    push_o  = 1'b0;
    write_o = 1'b0;
    next_o  = st_i;
    if (valid_i && hit_i) begin
      unique case (tt_i)
        TT_READ: if (st_i == ST_M) begin
          push_o  = 1'b1;
          write_o = 1'b1;
          next_o  = rd_next;
        end
        TT_READ_NC: if (st_i == ST_M) begin
          push_o  = 1'b1;
          write_o = 1'b1;
          next_o  = ST_E;  // keep write access, data already cleaned
        end
        TT_ICBI: if (ICBI_SNOOP_EN) begin
          write_o = 1'b1;
          next_o  = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/snoop_coherence_unit.sv
module snoop_coherence_unit
  import snoop_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int OFF_W         = 5,
  parameter int SETS          = 8,
  parameter bit MESI_EN       = 1'b1,
  parameter bit ICBI_SNOOP_EN = 1'b1,
  localparam int IDX_W        = $clog2(SETS),
  localparam int TAG_W        = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snp_valid_i,
  input  logic [4:0]        snp_tt_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [1:0]        fill_state_i,
  input  logic [ADDR_W-1:0] look_addr_i,
  output logic [1:0]        look_state_o,
  output logic              push_req_o,
  output logic [ADDR_W-1:0] push_addr_o,
  input  logic              push_done_i,
  output logic              retry_o,
  output logic              wr_valid_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [1:0]        wr_state_o
);
  typedef enum logic {F_IDLE, F_PUSH} fsm_e;

  fsm_e               fsm_q;
  logic [IDX_W-1:0]   pidx_q;
  logic [TAG_W-1:0]   ptag_q;
  cstate_e            pnext_q;
  logic               nitc_q;

  logic [IDX_W-1:0]   ridx [2];
  logic [TAG_W-1:0]   rtag [2];
  logic               rhit [2];
  cstate_e            rst  [2];

  logic               accept;
  logic               pol_push, pol_write;
  cstate_e            pol_next;
  logic               sn_we;
  logic [IDX_W-1:0]   sn_idx;
  logic [TAG_W-1:0]   sn_tag;
  cstate_e            sn_st;
  cstate_e            fill_st;
  logic               arr_we;
  logic [IDX_W-1:0]   arr_idx;
  logic [TAG_W-1:0]   arr_tag;
  cstate_e            arr_st;

  assign ridx[0] = snp_addr_i[OFF_W +: IDX_W];
  assign rtag[0] = snp_addr_i[ADDR_W-1 -: TAG_W];
  assign ridx[1] = look_addr_i[OFF_W +: IDX_W];
  assign rtag[1] = look_addr_i[ADDR_W-1 -: TAG_W];

  snoop_tag_array #(
    .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .NRD(2)
  ) u_array (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (arr_we),
    .widx_i(arr_idx),
    .wtag_i(arr_tag),
    .wst_i (arr_st),
    .ridx_i(ridx),
    .rtag_i(rtag),
    .hit_o (rhit),
    .st_o  (rst)
  );

  assign accept = snp_valid_i && (fsm_q == F_IDLE);

  snoop_policy #(
    .MESI_EN(MESI_EN), .ICBI_SNOOP_EN(ICBI_SNOOP_EN)
  ) u_policy (
    .valid_i(accept),
    .tt_i   (snp_tt_i),
    .hit_i  (rhit[0]),
    .st_i   (rst[0]),
    .push_o (pol_push),
    .write_o(pol_write),
    .next_o (pol_next)
  );

  // three-state variant stores S as E
  if (MESI_EN) begin : g_fill_mesi
    assign fill_st = cstate_e'(fill_state_i);
  end else begin : g_fill_mei
    assign fill_st = (cstate_e'(fill_state_i) == ST_S) ? ST_E : cstate_e'(fill_state_i);
  end

  always_comb begin
    sn_we  = 1'b0;
    sn_idx = ridx[0];
    sn_tag = rtag[0];
    sn_st  = pol_next;
    if (fsm_q == F_PUSH && push_done_i) begin
      sn_we  = 1'b1;
      sn_idx = pidx_q;
      sn_tag = ptag_q;
      sn_st  = pnext_q;
    end else if (pol_write && !pol_push) begin
      sn_we = 1'b1;
    end
  end

  // snoop update wins over a colliding fill
  assign arr_we  = sn_we || fill_valid_i;
  assign arr_idx = sn_we ? sn_idx : fill_addr_i[OFF_W +: IDX_W];
  assign arr_tag = sn_we ? sn_tag : fill_addr_i[ADDR_W-1 -: TAG_W];
  assign arr_st  = sn_we ? sn_st  : fill_st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q   <= F_IDLE;
      pidx_q  <= '0;
      ptag_q  <= '0;
      pnext_q <= ST_I;
      nitc_q  <= 1'b0;
    end else begin
      unique case (fsm_q)
        F_IDLE: if (pol_push) begin
          fsm_q   <= F_PUSH;
          pidx_q  <= ridx[0];
          ptag_q  <= rtag[0];
          pnext_q <= pol_next;
          nitc_q  <= (snp_tt_i == TT_READ_NC);
        end
        F_PUSH: if (push_done_i) fsm_q <= F_IDLE;
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  assign push_req_o   = (fsm_q == F_PUSH);
  assign retry_o      = (fsm_q == F_PUSH);
  assign push_addr_o  = {ptag_q, pidx_q, {OFF_W{1'b0}}};
  assign wr_valid_o   = sn_we;
  assign wr_idx_o     = sn_idx;
  assign wr_state_o   = sn_st;
  assign look_state_o = rhit[1] ? rst[1] : ST_I;

  AST_PUSH_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_req_o |-> retry_o);  // R5
  AST_PUSH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_req_o && !push_done_i |=> push_req_o && $stable(push_addr_o));  // R5
  AST_NITC_TO_E: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_req_o && push_done_i && nitc_q |-> wr_state_o == ST_E);  // R2
  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !rhit[0] |-> !wr_valid_o);  // R9
  AST_MISS_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !rhit[0] |=> !push_req_o);  // R9
  AST_ICBI_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && snp_tt_i == TT_ICBI |=> !push_req_o);  // R6

  if (!MESI_EN) begin : g_ast_mei
    AST_MEI_NO_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_valid_o |-> wr_state_o != ST_S);  // R4
  end
  if (!ICBI_SNOOP_EN) begin : g_ast_icbi_off
    AST_ICBI_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept && snp_tt_i == TT_ICBI |-> !wr_valid_o);  // R7
  end
endmodule

// File: tb/snoop_coherence_unit_tb.sv
`timescale 1ns/1ps
module snoop_coherence_unit_tb;
  import snoop_pkg::*;
  localparam int ADDR_W = 32, OFF_W = 5, SETS = 8, IDX_W = 3;
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              snp_valid = 0;
  logic [4:0]        snp_tt = '0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic              fill_valid = 0;
  logic [ADDR_W-1:0] fill_addr = '0;
  logic [1:0]        fill_state = '0;
  logic [ADDR_W-1:0] look_addr = '0;
  logic [1:0]        look_st   [2];
  logic              push_req  [2];
  logic [ADDR_W-1:0] push_addr [2];
  logic              done      [2];
  logic              retry     [2];
  logic              wr_valid  [2];
  logic [IDX_W-1:0]  wr_idx    [2];
  logic [1:0]        wr_state  [2];

  int n_chk = 0, n_err = 0;
  logic [TAG_W-1:0] m_tag [2][SETS];
  logic [1:0]       m_st  [2][SETS];

  initial begin done[0] = 0; done[1] = 0; end

  snoop_coherence_unit #(.MESI_EN(1'b1), .ICBI_SNOOP_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .snp_valid_i(snp_valid), .snp_tt_i(snp_tt),
    .snp_addr_i(snp_addr), .fill_valid_i(fill_valid), .fill_addr_i(fill_addr),
    .fill_state_i(fill_state), .look_addr_i(look_addr), .look_state_o(look_st[0]),
    .push_req_o(push_req[0]), .push_addr_o(push_addr[0]), .push_done_i(done[0]),
    .retry_o(retry[0]), .wr_valid_o(wr_valid[0]), .wr_idx_o(wr_idx[0]),
    .wr_state_o(wr_state[0]));

  snoop_coherence_unit #(.MESI_EN(1'b0), .ICBI_SNOOP_EN(1'b0)) u_dut_mei (
    .clk_i(clk), .rst_ni(rst_n), .snp_valid_i(snp_valid), .snp_tt_i(snp_tt),
    .snp_addr_i(snp_addr), .fill_valid_i(fill_valid), .fill_addr_i(fill_addr),
    .fill_state_i(fill_state), .look_addr_i(look_addr), .look_state_o(look_st[1]),
    .push_req_o(push_req[1]), .push_addr_o(push_addr[1]), .push_done_i(done[1]),
    .retry_o(retry[1]), .wr_valid_o(wr_valid[1]), .wr_idx_o(wr_idx[1]),
    .wr_state_o(wr_state[1]));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk_addr(int tag, int idx, int off);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[ADDR_W-1 -: TAG_W] = TAG_W'(tag);
    a[OFF_W +: IDX_W]    = IDX_W'(idx);
    a[OFF_W-1:0]         = OFF_W'(off);
    return a;
  endfunction

  function automatic logic [1:0] m_look(int v, logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] i;
    i = a[OFF_W +: IDX_W];
    if (m_st[v][i] != 2'b00 && m_tag[v][i] == a[ADDR_W-1 -: TAG_W]) return m_st[v][i];
    return 2'b00;
  endfunction

  // {push, write, next[1:0]}; v=0 four-state + invalidate on, v=1 three-state + off
  function automatic logic [3:0] m_snoop(int v, logic [4:0] tt, logic [ADDR_W-1:0] a);
    logic [1:0] s;
    s = m_look(v, a);
    if (s == 2'b00) return 4'b0000;
    if ((tt == 5'b01010 || tt == 5'b01011) && s == 2'b11) begin
      if (tt == 5'b01011) return 4'b1110;
      return (v == 0) ? 4'b1101 : 4'b1100;
    end
    if (tt == 5'b01101 && v == 0) return 4'b0100;
    return 4'b0000;
  endfunction

  task automatic look_chk(string req, logic [ADDR_W-1:0] a);
    look_addr = a;
    #1;
    for (int v = 0; v < 2; v++) chk(req, v ? "mei look" : "mesi look", 32'(look_st[v]), 32'(m_look(v, a)));
  endtask

  task automatic do_fill(logic [ADDR_W-1:0] a, logic [1:0] s);
    @(posedge clk); #1;
    fill_valid = 1; fill_addr = a; fill_state = s;
    @(posedge clk); #1;
    fill_valid = 0;
    for (int v = 0; v < 2; v++) begin
      m_tag[v][a[OFF_W +: IDX_W]] = a[ADDR_W-1 -: TAG_W];
      m_st[v][a[OFF_W +: IDX_W]]  = (v == 1 && s == 2'b01) ? 2'b10 : s;
    end
    look_chk((s == 2'b01) ? "R4" : "R1", a);
  endtask

  task automatic do_snoop(logic [4:0] tt, logic [ADDR_W-1:0] a, string req);
    logic [3:0] e [2];
    for (int v = 0; v < 2; v++) e[v] = m_snoop(v, tt, a);
    @(posedge clk); #1;
    snp_valid = 1; snp_tt = tt; snp_addr = a;
    @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      chk(req, "wr_valid", 32'(wr_valid[v]), 32'(e[v][2] && !e[v][3]));
      if (e[v][2] && !e[v][3]) chk(req, "wr_state", 32'(wr_state[v]), 32'(e[v][1:0]));
    end
    @(posedge clk); #1;
    snp_valid = 0;
    @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      chk(req, "push_req", 32'(push_req[v]), 32'(e[v][3]));
      chk(req, "retry", 32'(retry[v]), 32'(e[v][3]));
      if (e[v][3]) chk("R5", "push_addr", push_addr[v], {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}});
    end
    if (e[0][3] || e[1][3]) begin
      if (e[0][3] && e[1][3]) begin
        @(posedge clk); #1;
        snp_valid = 1; snp_tt = 5'b01101; snp_addr = a;
        @(negedge clk);
        for (int v = 0; v < 2; v++) chk("R5", "ignored snoop write", 32'(wr_valid[v]), 0);
        @(posedge clk); #1;
        snp_valid = 0;
        @(negedge clk);
        for (int v = 0; v < 2; v++) begin
          chk("R5", "push held", 32'(push_req[v]), 1);
          chk("R5", "addr held", push_addr[v], {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}});
        end
      end
      @(posedge clk); #1;
      done[0] = e[0][3]; done[1] = e[1][3];
      @(negedge clk);
      for (int v = 0; v < 2; v++) if (e[v][3]) begin
        chk(req, "done wr_valid", 32'(wr_valid[v]), 1);
        chk(req, "done wr_state", 32'(wr_state[v]), 32'(e[v][1:0]));
        chk(req, "done wr_idx", 32'(wr_idx[v]), 32'(a[OFF_W +: IDX_W]));
      end
      @(posedge clk); #1;
      done[0] = 0; done[1] = 0;
      @(negedge clk);
      for (int v = 0; v < 2; v++) chk("R5", "push released", 32'(push_req[v] | retry[v]), 0);
    end
    for (int v = 0; v < 2; v++) if (e[v][2]) m_st[v][a[OFF_W +: IDX_W]] = e[v][1:0];
    look_chk(req, a);
  endtask

  initial begin
    #(100000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int v = 0; v < 2; v++)
      for (int i = 0; i < SETS; i++) begin m_st[v][i] = 2'b00; m_tag[v][i] = '0; end
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      chk("R1", "reset push", 32'(push_req[v]), 0);
      chk("R1", "reset retry", 32'(retry[v]), 0);
      chk("R1", "reset wr_valid", 32'(wr_valid[v]), 0);
    end
    rst_n = 1;
    for (int i = 0; i < SETS; i++) look_chk("R1", mk_addr(0, i, 0));

    do_fill(mk_addr(1, 1, 0), 2'b11);
    do_snoop(5'b01011, mk_addr(1, 1, 4), "R2");
    do_fill(mk_addr(2, 2, 0), 2'b11);
    do_snoop(5'b01010, mk_addr(2, 2, 8), "R3");
    do_fill(mk_addr(3, 3, 0), 2'b01);
    do_snoop(5'b01010, mk_addr(3, 3, 0), "R8");
    do_snoop(5'b01011, mk_addr(1, 1, 0), "R8");
    do_fill(mk_addr(1, 4, 0), 2'b11);
    do_snoop(5'b01010, mk_addr(2, 4, 0), "R9");
    do_snoop(5'b01010, mk_addr(0, 5, 0), "R9");
    do_snoop(5'b00010, mk_addr(1, 4, 0), "R10");
    do_snoop(5'b01101, mk_addr(1, 4, 0), "R6_R7");
    do_fill(mk_addr(1, 6, 0), 2'b11);
    do_snoop(5'b01010, mk_addr(1, 6, 0), "R4");

    for (int k = 0; k < 400; k++) begin
      int r;
      logic [ADDR_W-1:0] a;
      logic [4:0] tt;
      r = int'($urandom % 8);
      a = mk_addr(int'($urandom % 3), int'($urandom % SETS), int'($urandom % 32));
      if (r < 3) do_fill(a, 2'($urandom % 4));
      else begin
        unique case (r)
          3: do_snoop(5'b01010, a, "R3");
          4: do_snoop(5'b01011, a, "R2");
          5: do_snoop(5'b01101, a, "R6_R7");
          6: do_snoop(5'b01010, a, "R8");
          default: begin
            tt = 5'($urandom % 32);
            if (tt == 5'b01010 || tt == 5'b01011 || tt == 5'b01101) tt = 5'b00000;
            do_snoop(tt, a, "R10");
          end
        endcase
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule